// File: doc/BRIEF.md
# Single-Register Load/Store Address Unit

This block sits between instruction decode and the data bus of a 32-bit core. For a single-register load or store it forms the effective address from a base register and an offset. The offset is either an immediate or a register value passed through a barrel shifter, and it is added to or subtracted from the base. The block also computes the base writeback value for the pre-indexed and post-indexed forms, and it drives a little-endian 32-bit memory port with byte enables and lane-replicated store data. On the way back it extracts the addressed byte or halfword and zero- or sign-extends it to 32 bits.

Plain loads and stores finish in one cycle, and the memory is expected to return read data in the same cycle. A swap request takes two cycles. The first is a read and the second is a write to the same address, with the bus lock held over both. The old memory value is presented as the load result in the second cycle. Misaligned accesses are flagged and do not reach memory. A load into the program counter raises a PC-write strobe.

Top module: `ls_addr_unit`

## Requirements
- R1: The memory address is base±offset when `mode_i` is 0 (offset) or 1 (pre-indexed), and it is the unmodified base when `mode_i` is 2 (post-indexed). `add_i`=1 adds and `add_i`=0 subtracts.
- R2: `wb_en_o` is high only for an accepted, aligned, non-swap access in mode 1 or 2, and `wb_val_o` is then base±offset. Mode 0 never writes back.
- R3: With `off_sel_reg_i`=1 the offset is `off_reg_i` shifted by `shift_amt_i` (5 bits), and `shift_type_i` selects the shift: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. With `off_sel_reg_i`=0 the offset is `off_imm_i` and is not shifted.
- R4: `size_i` is 0 for byte, 1 for halfword and 2 for word, and memory is little-endian. A byte uses enable bit addr[1:0] and its data is copied into all four lanes. A halfword uses enables 4'b0011 when addr[1]=0 and 4'b1100 when addr[1]=1, and its data is copied into both halves. A word uses 4'b1111.
- R5: A load returns the addressed byte or halfword in the low bits of `ld_data_o`. The upper bits are copies of its top bit when `signed_i`=1 and zero when `signed_i`=0. A word is returned unchanged.
- R6: A halfword with addr[0]=1, or a word with addr[1:0]≠0, raises `align_fault_o` in that cycle. In that cycle there is no memory request, no writeback and no load result.
- R7: A swap (`swap_i`=1) uses the base as its address. Its first cycle reads with the lock held. Its next cycle writes `st_data_i` to the same address with the lock still held, and returns the extended old value on `ld_data_o` with `ld_valid_o`. A swap never writes back.
- R8: `pc_write_o` is high exactly when a load result is valid and the destination is the program counter (`dest_pc_i`=1). This includes the result cycle of a swap.
- R9: A request presented during the write cycle of a swap is ignored and leaves the memory port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request this cycle |
| is_load_i | input | 1 | 1 load, 0 store |
| swap_i | input | 1 | Atomic read-then-write |
| base_i | input | 32 | Base register value |
| off_imm_i | input | 32 | Immediate offset |
| off_reg_i | input | 32 | Register offset before shifting |
| off_sel_reg_i | input | 1 | Select register offset |
| shift_type_i | input | 2 | Shift kind for the register offset |
| shift_amt_i | input | 5 | Shift amount |
| add_i | input | 1 | 1 add offset, 0 subtract |
| mode_i | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| signed_i | input | 1 | Sign-extend narrow loads |
| dest_pc_i | input | 1 | Load destination is the program counter |
| st_data_i | input | 32 | Register data to store |
| mem_rdata_i | input | 32 | Memory read data, same cycle |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Memory address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Lane-replicated store data |
| bus_lock_o | output | 1 | Bus held for a swap |
| wb_en_o | output | 1 | Base writeback enable |
| wb_val_o | output | 32 | New base value |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Extended load result |
| pc_write_o | output | 1 | Load targets the program counter |
| align_fault_o | output | 1 | Misaligned access |

## Verification
The hardest case to reach from the ports is the write cycle of a swap. In that cycle the address, size, store data and destination come from held state and not from the inputs, and the input port carries a request that must not leak through. The stimulus starts a byte swap and then, in the following cycle, drives a different pre-indexed word store with new base, data and size. The expected write cycle still carries the first request's address, lane and data, and the old value is read back and sign-extended. A plain load afterwards confirms which byte memory really received.

// File: rtl/ls_addr_pkg.sv
package ls_addr_pkg;
  typedef enum logic [1:0] {AM_OFFSET = 2'd0, AM_PRE = 2'd1, AM_POST = 2'd2, AM_RSVD = 2'd3} amode_e;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} asize_e;
  typedef enum logic [1:0] {SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3} shift_e;
endpackage

// File: rtl/ls_offset_shifter.sv
module ls_offset_shifter
  import ls_addr_pkg::*;
#(
  parameter int DW = 32,
  localparam int AW = $clog2(DW)
) (
  input  logic [DW-1:0] val_i,
  input  logic [1:0]    type_i,
  input  logic [AW-1:0] amt_i,
  output logic [DW-1:0] res_o
);
  logic [AW:0] rot_back;
  assign rot_back = AW'(0) + (AW+1)'(DW) - {1'b0, amt_i};

  always_comb begin
    unique case (shift_e'(type_i))
      SH_LSL:  res_o = val_i << amt_i;
      SH_LSR:  res_o = val_i >> amt_i;
      SH_ASR:  res_o = DW'($signed(val_i) >>> amt_i);
      default: res_o = (val_i >> amt_i) | (val_i << rot_back);
    endcase
  end
endmodule

// File: rtl/ls_lane_format.sv
module ls_lane_format
  import ls_addr_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic [1:0]    addr_lo_i,
  input  logic [1:0]    size_i,
  input  logic          sgn_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [DW-1:0] rdata_i,
  output logic [NB-1:0] be_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] ld_o,
  output logic          misalign_o
);
  logic [DW-1:0] byte_lane, half_lane;
  assign byte_lane = rdata_i >> {addr_lo_i, 3'b000};
  assign half_lane = rdata_i >> {addr_lo_i[1], 4'b0000};

  always_comb begin
    unique case (asize_e'(size_i))
      SZ_BYTE: begin
        be_o       = NB'(1) << addr_lo_i;
        wdata_o    = {NB{st_data_i[7:0]}};
        ld_o       = {{(DW-8){sgn_i & byte_lane[7]}}, byte_lane[7:0]};
        misalign_o = 1'b0;
      end
      SZ_HALF: begin
        be_o       = addr_lo_i[1] ? NB'(4'b1100) : NB'(4'b0011);
        wdata_o    = {(NB/2){st_data_i[15:0]}};
        ld_o       = {{(DW-16){sgn_i & half_lane[15]}}, half_lane[15:0]};
        misalign_o = addr_lo_i[0];
      end
      default: begin
        be_o       = '1;
        wdata_o    = st_data_i;
        ld_o       = rdata_i;
        misalign_o = |addr_lo_i;
      end
    endcase
  end
endmodule

// File: rtl/ls_swap_seq.sv
module ls_swap_seq #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [DW-1:0] ld_i,
  input  logic          dest_pc_i,
  output logic          wr_phase_o,
  output logic [DW-1:0] addr_o,
  output logic [1:0]    size_o,
  output logic [DW-1:0] st_data_o,
  output logic [DW-1:0] ld_o,
  output logic          dest_pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_phase_o <= 1'b0;
      addr_o     <= '0;
      size_o     <= '0;
      st_data_o  <= '0;
      ld_o       <= '0;
      dest_pc_o  <= 1'b0;
    end else begin
      wr_phase_o <= start_i;
      if (start_i) begin
        addr_o    <= addr_i;
        size_o    <= size_i;
        st_data_o <= st_data_i;
        ld_o      <= ld_i;
        dest_pc_o <= dest_pc_i;
      end
    end
  end
endmodule

// File: rtl/ls_addr_unit.sv
module ls_addr_unit
  import ls_addr_pkg::*;
#(
  parameter int DW = 32,
  localparam int AW = $clog2(DW),
  localparam int NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          is_load_i,
  input  logic          swap_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] off_imm_i,
  input  logic [DW-1:0] off_reg_i,
  input  logic          off_sel_reg_i,
  input  logic [1:0]    shift_type_i,
  input  logic [AW-1:0] shift_amt_i,
  input  logic          add_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic          signed_i,
  input  logic          dest_pc_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [NB-1:0] mem_be_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          bus_lock_o,
  output logic          wb_en_o,
  output logic [DW-1:0] wb_val_o,
  output logic          ld_valid_o,
  output logic [DW-1:0] ld_data_o,
  output logic          pc_write_o,
  output logic          align_fault_o
);
  logic [DW-1:0] shifted, offset, sum, ea, fmt_ld, fmt_wdata;
  logic [DW-1:0] h_addr, h_st, h_ld;
  logic [1:0]    h_size, cur_size;
  logic          h_dpc, wr_phase, misalign, go, start;
  logic [NB-1:0] fmt_be;

  ls_offset_shifter #(.DW(DW)) u_shift (
    .val_i(off_reg_i), .type_i(shift_type_i), .amt_i(shift_amt_i), .res_o(shifted)
  );

  assign offset = off_sel_reg_i ? shifted : off_imm_i;
  assign sum    = add_i ? base_i + offset : base_i - offset;
  assign ea     = (swap_i || amode_e'(mode_i) == AM_POST) ? base_i : sum;

  assign mem_addr_o = wr_phase ? h_addr : ea;
  assign cur_size   = wr_phase ? h_size : size_i;

  ls_lane_format #(.DW(DW)) u_lane (
    .addr_lo_i(mem_addr_o[1:0]), .size_i(cur_size), .sgn_i(signed_i),
    .st_data_i(wr_phase ? h_st : st_data_i), .rdata_i(mem_rdata_i),
    .be_o(fmt_be), .wdata_o(fmt_wdata), .ld_o(fmt_ld), .misalign_o(misalign)
  );

  // accepted, aligned access issued from the input port
  assign go    = req_i && !wr_phase && !misalign;
  assign start = go && swap_i;

  ls_swap_seq #(.DW(DW)) u_swap (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .addr_i(ea), .size_i(size_i),
    .st_data_i(st_data_i), .ld_i(fmt_ld), .dest_pc_i(dest_pc_i),
    .wr_phase_o(wr_phase), .addr_o(h_addr), .size_o(h_size), .st_data_o(h_st),
    .ld_o(h_ld), .dest_pc_o(h_dpc)
  );

  assign mem_be_o      = fmt_be;
  assign mem_wdata_o   = fmt_wdata;
  assign mem_req_o     = go || wr_phase;
  assign mem_we_o      = wr_phase || (go && !is_load_i && !swap_i);
  assign bus_lock_o    = start || wr_phase;
  assign align_fault_o = req_i && !wr_phase && misalign;
  assign wb_en_o       = go && !swap_i &&
                         (amode_e'(mode_i) == AM_PRE || amode_e'(mode_i) == AM_POST);
  assign wb_val_o      = sum;
  assign ld_valid_o    = wr_phase || (go && is_load_i && !swap_i);
  assign ld_data_o     = wr_phase ? h_ld : fmt_ld;
  assign pc_write_o    = ld_valid_o && (wr_phase ? h_dpc : dest_pc_i);

  assert_post_base_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !bus_lock_o && amode_e'(mode_i) == AM_POST) |-> mem_addr_o == base_i);
  assert_offset_no_wb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amode_e'(mode_i) == AM_OFFSET) |-> !wb_en_o);
  assert_byte_lane_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && cur_size == 2'd0) |-> $onehot(mem_be_o));
  assert_fault_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_fault_o |-> (!mem_req_o && !wb_en_o && !ld_valid_o));
  assert_swap_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_lock_o && !mem_we_o) |=> (bus_lock_o && mem_we_o && ld_valid_o &&
                                   mem_addr_o == $past(mem_addr_o) && !wb_en_o));
  assert_swap_once_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_lock_o && mem_we_o) |=> !(bus_lock_o && mem_we_o));
  assert_pc_needs_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_write_o |-> ld_valid_o);
endmodule

// File: tb/ls_addr_unit_tb.sv
module ls_addr_unit_tb;
  typedef struct {
    logic is_load, swap, sel_reg, add, sgn, dpc;
    logic [31:0] base, imm, oreg, sdata;
    logic [1:0] sh_t, mode, size;
    logic [4:0] sh_a;
  } op_t;

  typedef struct packed {
    logic req, we; logic [31:0] addr; logic [3:0] be; logic [31:0] wdata;
    logic lock, wb_en; logic [31:0] wb_val; logic ld_v; logic [31:0] ld;
    logic pcw, fault;
  } obs_t;

  logic clk = 0, rst_n = 0;
  logic req, is_load, swap, sel_reg, add, sgn, dpc;
  logic [31:0] base, imm, oreg, sdata, rdata;
  logic [1:0] sh_t, mode, size;
  logic [4:0] sh_a;
  logic mem_req, mem_we, lock, wb_en, ld_v, pcw, fault;
  logic [31:0] addr, wdata, wb_val, ld;
  logic [3:0] be;
  logic [31:0] mem [16];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  obs_t exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  ls_addr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .is_load_i(is_load), .swap_i(swap),
    .base_i(base), .off_imm_i(imm), .off_reg_i(oreg), .off_sel_reg_i(sel_reg),
    .shift_type_i(sh_t), .shift_amt_i(sh_a), .add_i(add), .mode_i(mode), .size_i(size),
    .signed_i(sgn), .dest_pc_i(dpc), .st_data_i(sdata), .mem_rdata_i(rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(addr), .mem_be_o(be),
    .mem_wdata_o(wdata), .bus_lock_o(lock), .wb_en_o(wb_en), .wb_val_o(wb_val),
    .ld_valid_o(ld_v), .ld_data_o(ld), .pc_write_o(pcw), .align_fault_o(fault)
  );

  assign rdata = mem[addr[5:2]];
  always @(posedge clk)
    if (mem_req && mem_we)
      for (int b = 0; b < 4; b++) if (be[b]) mem[addr[5:2]][8*b +: 8] <= wdata[8*b +: 8];

  function automatic logic [31:0] ref_shift(logic [31:0] v, logic [1:0] t, logic [4:0] a);
    case (t)
      2'd0: return v << a;
      2'd1: return v >> a;
      2'd2: return $signed(v) >>> a;
      default: return (a == 0) ? v : ((v >> a) | (v << (32 - a)));
    endcase
  endfunction

  function automatic logic [3:0] ref_be(logic [1:0] a, logic [1:0] s);
    if (s == 0) return 4'b0001 << a;
    if (s == 1) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] ref_wd(logic [31:0] d, logic [1:0] s);
    if (s == 0) return {4{d[7:0]}};
    if (s == 1) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [31:0] ref_ld(logic [31:0] w, logic [1:0] a, logic [1:0] s, logic g);
    logic [7:0] b8; logic [15:0] h16;
    b8 = w[8*a +: 8]; h16 = w[16*a[1] +: 16];
    if (s == 0) return {{24{g & b8[7]}}, b8};
    if (s == 1) return {{16{g & h16[15]}}, h16};
    return w;
  endfunction

  // zero the fields that carry no meaning in the given cycle
  function automatic obs_t mask(obs_t o);
    if (!o.req) o.be = '0;
    if (!o.we) o.wdata = '0;
    if (!o.wb_en) o.wb_val = '0;
    if (!o.ld_v) o.ld = '0;
    return o;
  endfunction

  task automatic apply(op_t o);
    req = 1; is_load = o.is_load; swap = o.swap; base = o.base; imm = o.imm; oreg = o.oreg;
    sel_reg = o.sel_reg; sh_t = o.sh_t; sh_a = o.sh_a; add = o.add; mode = o.mode;
    size = o.size; sgn = o.sgn; dpc = o.dpc; sdata = o.sdata;
  endtask

  function automatic op_t mk(logic ld_, logic [1:0] md, logic [1:0] sz, logic [31:0] b,
                             logic [31:0] im, logic ad);
    op_t o;
    o.is_load = ld_; o.swap = 0; o.sel_reg = 0; o.add = ad; o.sgn = 0; o.dpc = 0;
    o.base = b; o.imm = im; o.oreg = 0; o.sdata = 32'hA5C3_7E19;
    o.sh_t = 0; o.sh_a = 0; o.mode = md; o.size = sz;
    return o;
  endfunction

  // driver: one accepted op per cycle, expected result pushed to the scoreboard
  task automatic drive(op_t o, string tag);
    obs_t e; logic [31:0] off, sum, ea; logic mis;
    off = o.sel_reg ? ref_shift(o.oreg, o.sh_t, o.sh_a) : o.imm;
    sum = o.add ? o.base + off : o.base - off;
    ea  = (o.mode == 2'd2) ? o.base : sum;
    mis = (o.size == 1) ? ea[0] : (o.size == 0) ? 1'b0 : (ea[1:0] != 0);
    e = '0;
    e.addr = ea; e.fault = mis; e.req = !mis; e.we = !mis && !o.is_load;
    e.be = ref_be(ea[1:0], o.size); e.wdata = ref_wd(o.sdata, o.size);
    e.wb_en = !mis && (o.mode == 1 || o.mode == 2); e.wb_val = sum;
    e.ld_v = !mis && o.is_load; e.ld = ref_ld(mem[ea[5:2]], ea[1:0], o.size, o.sgn);
    e.pcw = e.ld_v && o.dpc;
    apply(o);
    exp_q.push_back(mask(e)); tag_q.push_back(tag);
    @(posedge clk); #1;
  endtask

  // swap: read cycle, then a write cycle while an unrelated request is on the port
  task automatic drive_swap(op_t o, op_t intruder, string tag);
    obs_t e; logic [31:0] old;
    old = mem[o.base[5:2]];
    e = '0;
    e.addr = o.base; e.req = 1; e.lock = 1; e.be = ref_be(o.base[1:0], o.size);
    apply(o);
    exp_q.push_back(mask(e)); tag_q.push_back({tag, " read"});
    @(posedge clk); #1;
    e.we = 1; e.wdata = ref_wd(o.sdata, o.size); e.ld_v = 1;
    e.ld = ref_ld(old, o.base[1:0], o.size, o.sgn); e.pcw = o.dpc;
    apply(intruder);
    exp_q.push_back(mask(e)); tag_q.push_back({tag, " write R9"});
    @(posedge clk); #1;
    req = 0;
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      obs_t a, e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      a.req = mem_req; a.we = mem_we; a.addr = addr; a.be = be; a.wdata = wdata;
      a.lock = lock; a.wb_en = wb_en; a.wb_val = wb_val; a.ld_v = ld_v; a.ld = ld;
      a.pcw = pcw; a.fault = fault;
      a = mask(a);
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    op_t o, x;
    for (int i = 0; i < 16; i++) mem[i] = 32'hF1E2_83C4 + i * 32'h0404_0404;
    req = 0; is_load = 0; swap = 0; base = 0; imm = 0; oreg = 0; sel_reg = 0; sh_t = 0;
    sh_a = 0; add = 1; mode = 0; size = 0; sgn = 0; dpc = 0; sdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (mem_req !== 0 || lock !== 0 || wb_en !== 0 || ld_v !== 0 || pcw !== 0) begin
      n_fail++;
      $display("FAIL reset R7: actual %b%b%b%b%b expected 00000", mem_req, lock, wb_en, ld_v, pcw);
    end
    rst_n = 1;
    @(posedge clk); #1;

    drive(mk(1, 0, 2, 32'h20, 32'h8, 1), "R1 offset word load add");
    drive(mk(0, 1, 2, 32'h30, 32'hC, 0), "R2 R4 pre-indexed word store sub");
    o = mk(1, 2, 0, 32'h27, 32'h10, 1); o.sgn = 1;
    drive(o, "R1 R2 R5 post-indexed signed byte lane 3");
    drive(mk(1, 0, 1, 32'h12, 32'h0, 1), "R5 unsigned half upper lane");
    o = mk(1, 0, 1, 32'h14, 32'h0, 1); o.sgn = 1;
    drive(o, "R5 signed half lower lane");
    drive(mk(0, 0, 0, 32'h1D, 32'h0, 1), "R4 byte store lane 1");
    drive(mk(0, 0, 1, 32'h2A, 32'h0, 1), "R4 half store upper lane");
    drive(mk(1, 0, 2, 32'h1C, 32'h0, 1), "R4 R5 read back after narrow stores");

    o = mk(1, 1, 2, 32'h20, 32'hDEAD, 1); o.sel_reg = 1; o.oreg = 32'h3; o.sh_t = 0; o.sh_a = 2;
    drive(o, "R3 lsl register offset, immediate ignored");
    o.oreg = 32'h100; o.sh_t = 1; o.sh_a = 6;
    drive(o, "R3 lsr register offset");
    o.oreg = 32'h8000_0000; o.sh_t = 2; o.sh_a = 29;
    drive(o, "R3 asr register offset");
    o.oreg = 32'h1; o.sh_t = 3; o.sh_a = 30; o.add = 0; o.base = 32'h3C;
    drive(o, "R3 ror register offset subtract");

    drive(mk(1, 1, 1, 32'h21, 32'h0, 1), "R6 misaligned half");
    drive(mk(0, 2, 2, 32'h22, 32'h0, 1), "R6 misaligned word post");
    o = mk(1, 0, 2, 32'h08, 32'h4, 1); o.dpc = 1;
    drive(o, "R8 load to program counter");
    o = mk(0, 0, 2, 32'h08, 32'h4, 1); o.dpc = 1;
    drive(o, "R8 store with pc destination");

    o = mk(1, 0, 0, 32'h35, 32'h0, 1); o.swap = 1; o.sgn = 1; o.sdata = 32'h0000_005A; o.dpc = 1;
    x = mk(0, 1, 2, 32'h04, 32'h8, 1); x.sdata = 32'h1234_5678;
    drive_swap(o, x, "R7 R8 byte swap");
    drive(mk(1, 0, 2, 32'h34, 32'h0, 1), "R7 R9 memory after swap");
    drive(mk(1, 0, 2, 32'h0C, 32'h0, 1), "R9 intruder store did not land");
    o = mk(1, 0, 2, 32'h18, 32'h0, 1); o.swap = 1; o.sdata = 32'hCAFE_F00D;
    x = mk(1, 0, 2, 32'h00, 32'h0, 1);
    drive_swap(o, x, "R7 word swap");
    drive(mk(1, 0, 2, 32'h18, 32'h0, 1), "R7 word swap result");
    o = mk(1, 0, 2, 32'h1A, 32'h0, 1); o.swap = 1;
    drive(o, "R6 R7 misaligned swap no lock");
    req = 0;

    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule